// File: doc/BRIEF.md
# Two-Level Branch Target Buffer

This block sits beside a fetch-address generator and answers, for each fetch address it is given, whether a taken branch lives there and where it goes. It keeps two direct-mapped target tables: a small fast table (16 sets) and a larger slow table (64 sets). A fast-table hit lets fetch redirect on the very next cycle, so taken branches can follow one another with no lost cycles. A hit found only in the slow table, or any prediction for an indirect branch, costs a fixed bubble of three cycles. During that bubble the block raises `stall` and the fetch generator produces no new address.

When neither table knows the address, the result is "not taken" and fetch continues in a straight line. The decoder later works out the target and presents it on the override port. That override redirects fetch and installs the branch in both tables. Resolved branches arrive on the update port, which fills the slow table. A slow-table hit copies its entry into the fast table so that the next visit is fast. A redirect on either port cuts short a bubble in progress.

Top module: `btb2_lookup`

## Requirements
- R1: After reset every entry of both tables is invalid, `stall` and `res_valid` are low, and the first lookup of any address reports not taken.
- R2: A lookup is accepted when `lk_valid` is high while `stall`, `upd_redirect` and `ovr_valid` are all low. Its result appears on `res_*` with `res_valid` high in the cycle after the accepting edge. `res_valid` is low in every other cycle.
- R3: A fast-table hit on a conditional (`kind` 0) or direct (`kind` 1) entry reports taken with the stored target and `res_bubbles` = 0, and leaves `stall` low. Lookups on consecutive cycles are then each accepted.
- R4: A hit in the slow table alone reports taken with the stored target and `res_bubbles` = 3. `stall` is then high for exactly three cycles, starting with the result cycle.
- R5: Any hit on an indirect entry (`kind` 2), even in the fast table, also reports `res_bubbles` = 3 with the same three-cycle stall.
- R6: A miss in both tables reports `res_taken` = 0, `res_target` = 0 and `res_bubbles` = 0, with no stall.
- R7: A slow-table-only hit copies the entry into the fast table and replaces the entry that held that fast-table set. The next lookup of the same address takes zero bubbles, and the displaced address falls back to the slow table.
- R8: Lookups presented while `stall` is high are dropped and produce no result.
- R9: `upd_redirect` or `ovr_valid` clears any bubble, so `stall` is low in the following cycle. A lookup presented in that same cycle is dropped.
- R10: An update with `upd_taken` = 1 writes the branch into the slow table only and invalidates a matching fast-table copy. An update with `upd_taken` = 0 invalidates matching entries in both tables.
- R11: An override writes the branch into both tables, so a later lookup of it is a fast-table hit.
- R12: Byte addresses are indexed from bit 2 upward, using 4 index bits in the fast table and 6 in the slow one. The next 8 bits above each index form a partial tag. Addresses that agree in those bits alias and share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Fetch address present this cycle |
| lk_pc | input | 32 | Fetch address to look up |
| upd_valid | input | 1 | Resolved branch write |
| upd_pc | input | 32 | Address of resolved branch |
| upd_target | input | 32 | Resolved target |
| upd_kind | input | 2 | Branch kind: 0 conditional, 1 direct, 2 indirect |
| upd_taken | input | 1 | 1 installs the branch, 0 removes it |
| upd_redirect | input | 1 | Back-end redirect, cancels a bubble |
| ovr_valid | input | 1 | Decoder-computed target for a branch both tables missed |
| ovr_pc | input | 32 | Address of overridden branch |
| ovr_target | input | 32 | Decoder-computed target |
| ovr_kind | input | 2 | Branch kind, same encoding as `upd_kind` |
| stall | output | 1 | Bubble in progress, no new fetch address |
| res_valid | output | 1 | Result of the lookup accepted last cycle |
| res_taken | output | 1 | A branch target was found |
| res_target | output | 32 | Predicted target, 0 when not taken |
| res_bubbles | output | 2 | Bubble cycles this prediction costs |

## Verification
A corrupted valid bit or tag in either table shows up at the ports on the very next lookup of that set. It appears as a wrong taken flag, or as a bubble count of 3 where 0 was due. A skipped promotion stays hidden until the same address is fetched again, so the trace revisits addresses right after their slow-table hits. A bubble counter that is off by one, or that ignores a cancel, changes the number of stalled cycles after a single slow prediction. It also lets a lookup made during the stall produce a result. The bench therefore counts stalled cycles per lookup and probes lookups inside the stall window.

// File: rtl/btb2_pkg.sv
package btb2_pkg;

   typedef enum logic [1:0] {
      BR_COND     = 2'd0,
      BR_DIRECT   = 2'd1,
      BR_INDIRECT = 2'd2
   } br_kind_e;

endpackage

// File: rtl/btb2_table.sv
module btb2_table
   import btb2_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   parameter int TAG_W  = 8,
   parameter int ALIGN  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_pc,
   output logic              rd_hit,
   output logic [ADDR_W-1:0] rd_target,
   output br_kind_e          rd_kind,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_pc,
   input  logic [ADDR_W-1:0] wr_target,
   input  br_kind_e          wr_kind,
   input  logic              kill_en,
   input  logic [ADDR_W-1:0] kill_pc
);

   localparam int IDX_W = $clog2(DEPTH);

   generate
      if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("btb2_table: DEPTH must be a power of two");
      end
      if (ALIGN + IDX_W + TAG_W > ADDR_W) begin : g_bad_split
         $error("btb2_table: index and tag exceed the address");
      end
   endgenerate

   function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] pc);
      return pc[ALIGN +: IDX_W];
   endfunction

   function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
      return pc[ALIGN + IDX_W +: TAG_W];
   endfunction

   logic [DEPTH-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q [DEPTH];
   logic [ADDR_W-1:0] tgt_q [DEPTH];
   br_kind_e          kind_q [DEPTH];

   logic [IDX_W-1:0] ridx, widx, kidx;
   logic             kill_match;
   wire              unused_pc_bits = ^{rd_pc, wr_pc, kill_pc};

   assign ridx = idx_of(rd_pc);
   assign widx = idx_of(wr_pc);
   assign kidx = idx_of(kill_pc);
   assign kill_match = kill_en && vld_q[kidx] && (tag_q[kidx] == tag_of(kill_pc));

   // A write to the same set overrides an invalidation in that cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (kill_match && !(wr_en && widx == kidx)) vld_q[kidx] <= 1'b0;
         if (wr_en) vld_q[widx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[widx]  <= tag_of(wr_pc);
         tgt_q[widx]  <= wr_target;
         kind_q[widx] <= wr_kind;
      end
   end

   assign rd_hit    = vld_q[ridx] && (tag_q[ridx] == tag_of(rd_pc));
   assign rd_target = tgt_q[ridx];
   assign rd_kind   = kind_q[ridx];

   // R10/R11: a written set reads back as valid on the following cycle
   p_write_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(widx)]);

endmodule

// File: rtl/btb2_bubble.sv
module btb2_bubble #(
   parameter int PENALTY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic cancel,
   output logic stall
);

   generate
      if (PENALTY == 0) begin : g_no_bubble
         wire unused_ctl = ^{clk, rst_n, load, cancel};
         assign stall = 1'b0;
      end else begin : g_counter
         localparam int CNT_W = $clog2(PENALTY + 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cancel)         cnt_q <= '0;
            else if (load)           cnt_q <= CNT_W'(PENALTY);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end

         assign stall = (cnt_q != '0);

         // R9: a redirect leaves no bubble behind
         p_cancel_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            cancel |=> !stall);
         // R8: no new bubble is started while one is running
         p_load_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
            load |-> !stall);
      end
   endgenerate

endmodule

// File: rtl/btb2_lookup.sv
module btb2_lookup
   import btb2_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int L1_DEPTH = 16,
   parameter int L2_DEPTH = 64,
   parameter int TAG_W    = 8,
   parameter int ALIGN    = 2,
   parameter int PENALTY  = 3,
   localparam int BUB_W   = (PENALTY > 0) ? $clog2(PENALTY + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_pc,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic [1:0]        upd_kind,
   input  logic              upd_taken,
   input  logic              upd_redirect,
   input  logic              ovr_valid,
   input  logic [ADDR_W-1:0] ovr_pc,
   input  logic [ADDR_W-1:0] ovr_target,
   input  logic [1:0]        ovr_kind,
   output logic              stall,
   output logic              res_valid,
   output logic              res_taken,
   output logic [ADDR_W-1:0] res_target,
   output logic [BUB_W-1:0]  res_bubbles
);

   generate
      if (L2_DEPTH <= L1_DEPTH) begin : g_bad_levels
         $error("btb2_lookup: second level must be larger than the first");
      end
      if (TAG_W < 1 || ALIGN < 0) begin : g_bad_tag
         $error("btb2_lookup: TAG_W must be at least 1");
      end
   endgenerate

   logic              cancel, accept;
   logic              l1_hit, l2_hit, hit_any, slow, promote;
   logic [ADDR_W-1:0] l1_tgt, l2_tgt, sel_tgt;
   br_kind_e          l1_kind, l2_kind, sel_kind;

   logic              l1_wr_en, l2_wr_en, l2_kill_en;
   logic [ADDR_W-1:0] l1_wr_pc, l1_wr_tgt, l2_wr_pc, l2_wr_tgt;
   br_kind_e          l1_wr_kind, l2_wr_kind;

   assign cancel = upd_redirect | ovr_valid;
   assign accept = lk_valid & ~stall & ~cancel;

   assign hit_any  = l1_hit | l2_hit;
   assign sel_tgt  = l1_hit ? l1_tgt  : l2_tgt;
   assign sel_kind = l1_hit ? l1_kind : l2_kind;
   assign slow     = hit_any & (~l1_hit | (sel_kind == BR_INDIRECT));
   assign promote  = accept & ~l1_hit & l2_hit;

   // Fast table: override first, then promotion; any update drops a stale copy.
   assign l1_wr_en   = ovr_valid | promote;
   assign l1_wr_pc   = ovr_valid ? ovr_pc : lk_pc;
   assign l1_wr_tgt  = ovr_valid ? ovr_target : l2_tgt;
   assign l1_wr_kind = ovr_valid ? br_kind_e'(ovr_kind) : l2_kind;

   // Slow table: override first, then taken updates; not-taken updates remove.
   assign l2_wr_en   = ovr_valid | (upd_valid & upd_taken);
   assign l2_wr_pc   = ovr_valid ? ovr_pc : upd_pc;
   assign l2_wr_tgt  = ovr_valid ? ovr_target : upd_target;
   assign l2_wr_kind = ovr_valid ? br_kind_e'(ovr_kind) : br_kind_e'(upd_kind);
   assign l2_kill_en = upd_valid & ~upd_taken;

   btb2_table #(.ADDR_W(ADDR_W), .DEPTH(L1_DEPTH), .TAG_W(TAG_W), .ALIGN(ALIGN)) u_l1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (lk_pc),
      .rd_hit    (l1_hit),
      .rd_target (l1_tgt),
      .rd_kind   (l1_kind),
      .wr_en     (l1_wr_en),
      .wr_pc     (l1_wr_pc),
      .wr_target (l1_wr_tgt),
      .wr_kind   (l1_wr_kind),
      .kill_en   (upd_valid),
      .kill_pc   (upd_pc)
   );

   btb2_table #(.ADDR_W(ADDR_W), .DEPTH(L2_DEPTH), .TAG_W(TAG_W), .ALIGN(ALIGN)) u_l2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (lk_pc),
      .rd_hit    (l2_hit),
      .rd_target (l2_tgt),
      .rd_kind   (l2_kind),
      .wr_en     (l2_wr_en),
      .wr_pc     (l2_wr_pc),
      .wr_target (l2_wr_tgt),
      .wr_kind   (l2_wr_kind),
      .kill_en   (l2_kill_en),
      .kill_pc   (upd_pc)
   );

   btb2_bubble #(.PENALTY(PENALTY)) u_bubble (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept & slow),
      .cancel (cancel),
      .stall  (stall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_taken   <= 1'b0;
         res_target  <= '0;
         res_bubbles <= '0;
      end else begin
         res_valid <= accept;
         if (accept) begin
            res_taken   <= hit_any;
            res_target  <= hit_any ? sel_tgt : '0;
            res_bubbles <= slow ? BUB_W'(PENALTY) : '0;
         end
      end
   end

   // R2: exactly one result per accepted lookup, one cycle later
   p_result_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> res_valid);
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !res_valid);
   // R3: fast-table hit on a non-indirect branch costs nothing
   p_fast_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && l1_hit && l1_kind != BR_INDIRECT) |=>
         (res_taken && res_bubbles == '0 && !stall));
   // R4: slow-table-only hit pays the full bubble
   p_slow_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !l1_hit && l2_hit) |=>
         (res_taken && res_bubbles == BUB_W'(PENALTY) && (PENALTY == 0 || stall)));
   // R6: double miss predicts nothing
   p_double_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !l1_hit && !l2_hit) |=>
         (!res_taken && res_target == '0 && res_bubbles == '0));
   // R8: a stalled cycle yields no result
   p_stall_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !res_valid);

endmodule

// File: tb/btb2_lookup_test.sv
`timescale 1ns/1ps
module btb2_lookup_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [31:0] upd_target = '0;
   logic [1:0]  upd_kind = '0;
   logic        upd_taken = 1'b0;
   logic        upd_redirect = 1'b0;
   logic        ovr_valid = 1'b0;
   logic [31:0] ovr_pc = '0;
   logic [31:0] ovr_target = '0;
   logic [1:0]  ovr_kind = '0;
   logic        stall, res_valid, res_taken;
   logic [31:0] res_target;
   logic [1:0]  res_bubbles;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   btb2_lookup uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
      .upd_kind(upd_kind), .upd_taken(upd_taken), .upd_redirect(upd_redirect),
      .ovr_valid(ovr_valid), .ovr_pc(ovr_pc), .ovr_target(ovr_target),
      .ovr_kind(ovr_kind), .stall(stall), .res_valid(res_valid),
      .res_taken(res_taken), .res_target(res_target), .res_bubbles(res_bubbles)
   );

   // Addresses: A and B share fast set 0 but not slow sets; C sits in set 2;
   // D is never written; A2 aliases A in both tables (R12); E shares fast set 0.
   localparam logic [31:0] PA  = 32'h0000_0100;
   localparam logic [31:0] PB  = 32'h0000_0140;
   localparam logic [31:0] PC  = 32'h0000_0208;
   localparam logic [31:0] PD  = 32'h0000_0300;
   localparam logic [31:0] PA2 = 32'h0001_0100;
   localparam logic [31:0] PE  = 32'h0000_0400;

   localparam logic [1:0] OP_LOOK = 2'd0, OP_UPDT = 2'd1, OP_UPDN = 2'd2, OP_OVR = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] pc;
      logic [31:0] tgt;
      logic [1:0]  kind;
      logic        e_tk;
      logic [31:0] e_tgt;
      logic [1:0]  e_bub;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{OP_LOOK, PA,  32'h0,    2'd0, 1'b0, 32'h0,    2'd0, 4'd6},  // R6 empty tables
      '{OP_UPDT, PA,  32'h1000, 2'd1, 1'b0, 32'h0,    2'd0, 4'd10},
      '{OP_LOOK, PA,  32'h0,    2'd0, 1'b1, 32'h1000, 2'd3, 4'd4},  // R4 slow hit
      '{OP_LOOK, PA,  32'h0,    2'd0, 1'b1, 32'h1000, 2'd0, 4'd7},  // R7 promoted
      '{OP_UPDT, PB,  32'h2000, 2'd1, 1'b0, 32'h0,    2'd0, 4'd10},
      '{OP_LOOK, PB,  32'h0,    2'd0, 1'b1, 32'h2000, 2'd3, 4'd4},
      '{OP_LOOK, PA,  32'h0,    2'd0, 1'b1, 32'h1000, 2'd3, 4'd7},  // R7 displaced
      '{OP_OVR,  PC,  32'h3000, 2'd2, 1'b0, 32'h0,    2'd0, 4'd11},
      '{OP_LOOK, PC,  32'h0,    2'd0, 1'b1, 32'h3000, 2'd3, 4'd5},  // R5 indirect
      '{OP_OVR,  PC,  32'h3100, 2'd1, 1'b0, 32'h0,    2'd0, 4'd11},
      '{OP_LOOK, PC,  32'h0,    2'd0, 1'b1, 32'h3100, 2'd0, 4'd11}, // R11
      '{OP_LOOK, PD,  32'h0,    2'd0, 1'b0, 32'h0,    2'd0, 4'd6},
      '{OP_UPDN, PA,  32'h0,    2'd1, 1'b0, 32'h0,    2'd0, 4'd10},
      '{OP_LOOK, PA,  32'h0,    2'd0, 1'b0, 32'h0,    2'd0, 4'd10}, // R10 removed
      '{OP_UPDT, PA,  32'h1000, 2'd1, 1'b0, 32'h0,    2'd0, 4'd10},
      '{OP_LOOK, PA,  32'h0,    2'd0, 1'b1, 32'h1000, 2'd3, 4'd10}, // R10 slow only
      '{OP_LOOK, PA2, 32'h0,    2'd0, 1'b1, 32'h1000, 2'd0, 4'd12}  // R12 alias
   };

   task automatic chk(input int req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Present one lookup; returns at the negedge where its result is visible.
   task automatic look(input logic [31:0] pc);
      lk_valid = 1'b1;
      lk_pc    = pc;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic count_stall(output int n);
      n = 0;
      while (stall && n < 8) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic check_result(input int req, input logic tk, input logic [31:0] tg,
                               input logic [1:0] bub);
      int n;
      chk(req, "res_valid", 32'(res_valid), 32'd1);
      chk(req, "res_taken", 32'(res_taken), 32'(tk));
      chk(req, "res_target", res_target, tg);
      chk(req, "res_bubbles", 32'(res_bubbles), 32'(bub));
      count_stall(n);
      chk(req, "stall cycles", 32'(n), 32'(bub));
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(1, "stall in reset", 32'(stall), 32'd0);
      chk(1, "res_valid in reset", 32'(res_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(2, "res_valid idle", 32'(res_valid), 32'd0);

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            OP_LOOK: begin
               look(VECS[i].pc);
               check_result(int'(VECS[i].req), VECS[i].e_tk, VECS[i].e_tgt, VECS[i].e_bub);
            end
            OP_UPDT, OP_UPDN: begin
               upd_valid = 1'b1; upd_pc = VECS[i].pc; upd_target = VECS[i].tgt;
               upd_kind = VECS[i].kind; upd_taken = (VECS[i].op == OP_UPDT);
               @(negedge clk);
               upd_valid = 1'b0;
            end
            default: begin
               ovr_valid = 1'b1; ovr_pc = VECS[i].pc; ovr_target = VECS[i].tgt;
               ovr_kind = VECS[i].kind;
               @(negedge clk);
               ovr_valid = 1'b0;
            end
         endcase
      end

      // R3: back-to-back fast hits, both accepted, no stall
      lk_valid = 1'b1; lk_pc = PC;
      @(negedge clk);
      lk_pc = PA2;
      chk(3, "first res_valid", 32'(res_valid), 32'd1);
      chk(3, "first target", res_target, 32'h3100);
      chk(3, "first stall", 32'(stall), 32'd0);
      @(negedge clk);
      lk_valid = 1'b0;
      chk(3, "second res_valid", 32'(res_valid), 32'd1);
      chk(3, "second target", res_target, 32'h1000);
      chk(3, "second bubbles", 32'(res_bubbles), 32'd0);
      chk(3, "second stall", 32'(stall), 32'd0);

      // R8: lookups during the bubble are dropped (B is slow-only here)
      look(PB);
      chk(8, "slow hit target", res_target, 32'h2000);
      chk(8, "stall raised", 32'(stall), 32'd1);
      lk_valid = 1'b1; lk_pc = PD;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(8, "dropped lookup", 32'(res_valid), 32'd0);
      end
      lk_valid = 1'b0;
      chk(8, "stall over", 32'(stall), 32'd0);

      // R9: back-end redirect cancels the bubble and drops a same-cycle lookup
      look(PA);
      chk(9, "stall before redirect", 32'(stall), 32'd1);
      upd_redirect = 1'b1; lk_valid = 1'b1; lk_pc = PC;
      @(negedge clk);
      upd_redirect = 1'b0; lk_valid = 1'b0;
      chk(9, "stall after redirect", 32'(stall), 32'd0);
      chk(9, "lookup dropped", 32'(res_valid), 32'd0);
      look(PC);
      check_result(9, 1'b1, 32'h3100, 2'd0);

      // R9/R11: decoder override cancels a bubble and installs a fast entry
      look(PB);
      chk(9, "stall before override", 32'(stall), 32'd1);
      ovr_valid = 1'b1; ovr_pc = PE; ovr_target = 32'h4000; ovr_kind = 2'd1;
      @(negedge clk);
      ovr_valid = 1'b0;
      chk(9, "stall after override", 32'(stall), 32'd0);
      look(PE);
      check_result(11, 1'b1, 32'h4000, 2'd0);

      // R1: reset clears both tables
      rst_n = 1'b0;
      @(negedge clk);
      chk(1, "res_valid after reset", 32'(res_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      look(PC);
      check_result(1, 1'b0, 32'h0, 2'd0);
      count_stall(n);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule